// File: doc/BRIEF.md
# Eight-Pin GPIO Expander Register Bank

This block holds the configuration and data registers for an eight-pin general-purpose I/O port. A bus master reads and writes byte-wide registers through a simple strobe interface. The bank drives a direction, an output value and a pull-up enable for each pin. It takes in the raw pad levels and returns the port state, with optional inversion for each bit. Bit n of every register belongs to pin n.

The port register and the output latch are separate. Writing the port register loads the latch. Reading the port register returns the live pad levels after the polarity register has been applied. Reading the latch register returns only the latch contents. The interrupt flag and capture registers belong to a separate interrupt unit. The bank only mirrors them on reads. Reading the port or the capture register sends a one-cycle clear pulse to that unit. The interrupt configuration registers are exported as outputs for the interrupt unit to use.

Reads are handled by a two-state machine. In `RD_IDLE` no read data is presented. An accepted read (read strobe high with the write strobe low) moves it to `RD_RESP`. `RD_RESP` lasts one cycle and presents the data. From `RD_RESP` a further accepted read keeps it in `RD_RESP` (back-to-back reads). Otherwise it returns to `RD_IDLE`. Writes take effect at the clock edge that samples them.

Top module: `gpx_bank`

## Requirements
- R1: After reset the direction register reads 0xFF and every other stored register reads 0x00. So `pin_is_input` is 0xFF, and `pin_out`, `pin_pullup` and all exported configuration bytes are 0x00.
- R2: Register 0x00 sets direction. A 1 in bit n makes pin n an input. A write shows on `pin_is_input` in the cycle after the write strobe is sampled.
- R3: A read of address 0x09 (port) returns `pad_in` XOR the polarity register (address 0x01), using the pad levels present at the sampling edge.
- R4: A write to 0x09 or to 0x0A loads the output latch, which drives `pin_out`. A read of 0x0A returns the latch and not the pad levels.
- R5: `pin_pullup` bit n is the pull-up register (address 0x06) bit n only while pin n is an input. Otherwise it is 0.
- R6: Addresses 0x07 and 0x08 read back `irq_flags_in` and `irq_cap_in`. Writes to these addresses change no stored register.
- R7: An accepted read presents `bus_rdata` with `bus_rvalid` high for exactly the one cycle after its sampling edge. Consecutive reads on consecutive cycles each get their own response cycle.
- R8: Reads of addresses above 0x0A return 0x00. Writes to them change no stored register.
- R9: `irq_clr` pulses for the same single cycle as `bus_rvalid` when, and only when, the read address was 0x08 or 0x09.
- R10: Registers 0x02 (interrupt enable), 0x03 (compare default), 0x04 (interrupt control) and 0x05 (configuration) read back what was written. They drive `irq_en`, `irq_ref`, `irq_mode` and `cfg_word`.
- R11: If read and write strobes are both high, the write is performed and the read is dropped (no `bus_rvalid`, no `irq_clr`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (5) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response cycle |
| pad_in | input | 8 | Raw pad levels |
| pin_is_input | output | 8 | 1 = pin is an input |
| pin_out | output | 8 | Output latch value for pins |
| pin_pullup | output | 8 | Effective pull-up enable |
| irq_flags_in | input | 8 | Flag byte from interrupt unit |
| irq_cap_in | input | 8 | Capture byte from interrupt unit |
| irq_clr | output | 1 | One-cycle clear pulse toward interrupt unit |
| irq_en | output | 8 | Interrupt enable register |
| irq_ref | output | 8 | Compare default register |
| irq_mode | output | 8 | Interrupt control register |
| cfg_word | output | 8 | Configuration register |

## Verification
A write is visible on the pin outputs and exported configuration bytes one edge after it is sampled. A read's data, valid flag and clear pulse all appear together for the single cycle after the sampling edge. The bench drives every stimulus at a falling edge and checks the result at the next falling edge, which is half a period after the one rising edge that produces it. In back-to-back reads it checks each response in the cycle that follows its own strobe. After a simultaneous strobe it confirms that the valid flag stays low in that same cycle.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int GPX_W    = 8;
    localparam int A_DIR    = 0;
    localparam int A_POL    = 1;
    localparam int A_IEN    = 2;
    localparam int A_DEF    = 3;
    localparam int A_ICTL   = 4;
    localparam int A_MODE   = 5;
    localparam int A_PULL   = 6;
    localparam int A_FLAG   = 7;
    localparam int A_CAP    = 8;
    localparam int A_PORT   = 9;
    localparam int A_LAT    = 10;
    // stored slots: 0..6 follow their address, slot 7 is the latch
    localparam int N_SLOTS  = 8;
    localparam int SL_LAT   = 7;

    typedef logic [GPX_W-1:0] gpx_byte_t;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    function automatic gpx_byte_t slot_reset(input int s);
        return (s == A_DIR) ? '1 : '0;
    endfunction
endpackage

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  gpx_byte_t                          wdata,
    output logic [N_SLOTS-1:0][GPX_W-1:0]      slot_q
);
    logic [N_SLOTS-1:0] hit;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        if (g == SL_LAT) begin : g_latch
            assign hit[g] = (addr == ADDR_W'(A_PORT)) || (addr == ADDR_W'(A_LAT));
        end else begin : g_plain
            assign hit[g] = (addr == ADDR_W'(g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= slot_reset(g);
            end else if (wr_en && hit[g]) begin
                slot_q[g] <= wdata;
            end
        end
    end

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_DIR)) |=> (slot_q[A_DIR] == $past(wdata)));

    // R4
    port_to_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(A_PORT)) |=> (slot_q[SL_LAT] == $past(wdata)));

    // R6
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(A_FLAG) || addr == ADDR_W'(A_CAP))) |=> $stable(slot_q));

    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > ADDR_W'(A_LAT)) |=> $stable(slot_q));
endmodule

// File: rtl/gpx_pin_ctrl.sv
module gpx_pin_ctrl
    import gpx_pkg::*;
(
    input  gpx_byte_t dir_q,
    input  gpx_byte_t pol_q,
    input  gpx_byte_t pull_q,
    input  gpx_byte_t latch_q,
    input  gpx_byte_t pad_in,
    output gpx_byte_t pin_is_input,
    output gpx_byte_t pin_out,
    output gpx_byte_t pin_pullup,
    output gpx_byte_t port_view
);
    for (genvar i = 0; i < GPX_W; i++) begin : g_pin
        assign pin_is_input[i] = dir_q[i];
        assign pin_out[i]      = latch_q[i];
        assign pin_pullup[i]   = pull_q[i] & dir_q[i];
        assign port_view[i]    = pad_in[i] ^ pol_q[i];
    end

    // R5
    always_comb begin
        pullup_gate_chk: assert ((pin_pullup & ~pin_is_input) == '0);
    end
endmodule

// File: rtl/gpx_rd_fsm.sv
module gpx_rd_fsm
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [N_SLOTS-1:0][GPX_W-1:0]  slot_q,
    input  gpx_byte_t                      port_view,
    input  gpx_byte_t                      flags_in,
    input  gpx_byte_t                      cap_in,
    output gpx_byte_t                      rdata,
    output logic                           rvalid,
    output logic                           clr_pulse
);
    rd_state_e state_q, state_d;
    logic      accept;
    logic      clr_hit;
    gpx_byte_t mux_d;

    assign accept  = rd_en && !wr_en;
    assign clr_hit = (addr == ADDR_W'(A_CAP)) || (addr == ADDR_W'(A_PORT));

    always_comb begin
        mux_d = '0;
        if (addr < ADDR_W'(A_FLAG)) begin
            mux_d = slot_q[addr[2:0]];
        end else if (addr == ADDR_W'(A_FLAG)) begin
            mux_d = flags_in;
        end else if (addr == ADDR_W'(A_CAP)) begin
            mux_d = cap_in;
        end else if (addr == ADDR_W'(A_PORT)) begin
            mux_d = port_view;
        end else if (addr == ADDR_W'(A_LAT)) begin
            mux_d = slot_q[SL_LAT];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = accept ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = accept ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata     <= '0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= accept && clr_hit;
            if (accept) rdata <= mux_d;
        end
    end

    assign rvalid = (state_q == RD_RESP);

    // R7
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rvalid);

    // R7
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept) |=> !rvalid);

    // R9
    clr_with_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |-> rvalid);

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!rvalid && !clr_pulse));

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && addr > ADDR_W'(A_LAT)) |=> (rdata == '0));
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_rvalid,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pin_is_input,
    output logic [7:0]        pin_out,
    output logic [7:0]        pin_pullup,
    input  logic [7:0]        irq_flags_in,
    input  logic [7:0]        irq_cap_in,
    output logic              irq_clr,
    output logic [7:0]        irq_en,
    output logic [7:0]        irq_ref,
    output logic [7:0]        irq_mode,
    output logic [7:0]        cfg_word
);
    logic [N_SLOTS-1:0][GPX_W-1:0] slot_q;
    gpx_byte_t                     port_view;

    gpx_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .slot_q (slot_q)
    );

    gpx_pin_ctrl u_pins (
        .dir_q        (slot_q[A_DIR]),
        .pol_q        (slot_q[A_POL]),
        .pull_q       (slot_q[A_PULL]),
        .latch_q      (slot_q[SL_LAT]),
        .pad_in       (pad_in),
        .pin_is_input (pin_is_input),
        .pin_out      (pin_out),
        .pin_pullup   (pin_pullup),
        .port_view    (port_view)
    );

    gpx_rd_fsm #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .slot_q    (slot_q),
        .port_view (port_view),
        .flags_in  (irq_flags_in),
        .cap_in    (irq_cap_in),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .clr_pulse (irq_clr)
    );

    assign irq_en   = slot_q[A_IEN];
    assign irq_ref  = slot_q[A_DEF];
    assign irq_mode = slot_q[A_ICTL];
    assign cfg_word = slot_q[A_MODE];

    // R10
    ien_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_IEN)) |=> (irq_en == $past(bus_wdata)));
endmodule

// File: tb/gpx_bank_tb.sv
module gpx_bank_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0, pad_in = '0, flg = '0, cap = '0;
    logic [7:0]    bus_rdata, pin_is_input, pin_out, pin_pullup;
    logic [7:0]    irq_en, irq_ref, irq_mode, cfg_word;
    logic          bus_rvalid, irq_clr;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] m [0:7];   // model slots: dir,pol,ien,def,ictl,mode,pull,latch
    int unused_seed;

    always #10 clk = ~clk;

    gpx_bank #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pin_is_input(pin_is_input),
        .pin_out(pin_out), .pin_pullup(pin_pullup), .irq_flags_in(flg),
        .irq_cap_in(cap), .irq_clr(irq_clr), .irq_en(irq_en), .irq_ref(irq_ref),
        .irq_mode(irq_mode), .cfg_word(cfg_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        if (a <= 6)  return m[a];
        if (a == 7)  return flg;
        if (a == 8)  return cap;
        if (a == 9)  return pad_in ^ m[1];
        if (a == 10) return m[7];
        return 8'h00;
    endfunction

    function automatic void model_write(input int a, input logic [7:0] d);
        if (a <= 6) m[a] = d;
        else if (a == 9 || a == 10) m[7] = d;
    endfunction

    task automatic check_pins(input string tag);
        chk(pin_is_input == m[0], {tag, " R2 dir"}, pin_is_input, m[0]);
        chk(pin_out == m[7], {tag, " R4 latch"}, pin_out, m[7]);
        chk(pin_pullup == (m[6] & m[0]), {tag, " R5 pullup"}, pin_pullup, m[6] & m[0]);
        chk({irq_en, irq_ref, irq_mode, cfg_word} == {m[2], m[3], m[4], m[5]},
            {tag, " R10 export"}, {irq_en, irq_ref}, {m[2], m[3]});
    endtask

    // drive at negedge, check at following negedge
    task automatic do_write(input int a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        chk(bus_rvalid == 1'b0, "R11 no resp on write", bus_rvalid, 0);
        check_pins(a > 10 ? "R8" : (a == 7 || a == 8) ? "R6" : "wr");
    endtask

    task automatic do_read(input int a);
        logic [7:0] e;
        bit ec;
        bus_rd = 1'b1; bus_addr = AW'(a);
        e = exp_read(a);
        ec = (a == 8 || a == 9);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rvalid == 1'b1, "R7 rvalid", bus_rvalid, 1);
        chk(bus_rdata == e, a == 9 ? "R3 port read" : a > 10 ? "R8 unmapped read" : "R6/R4/R10 read",
            bus_rdata, e);
        chk(irq_clr == ec, "R9 clr pulse", irq_clr, ec);
        @(negedge clk);
        chk(bus_rvalid == 1'b0 && irq_clr == 1'b0, "R7 single cycle", bus_rvalid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        unused_seed = $urandom(32'd4242);
        m[0] = 8'hFF;
        for (int i = 1; i < 8; i++) m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(pin_is_input == 8'hFF, "R1 dir reset", pin_is_input, 8'hFF);
        chk(pin_out == 8'h00 && pin_pullup == 8'h00, "R1 out/pull reset", pin_out, 0);
        chk({irq_en, irq_ref, irq_mode, cfg_word} == 32'h0, "R1 cfg reset", irq_en, 0);
        chk(bus_rvalid == 1'b0 && irq_clr == 1'b0, "R1 idle", bus_rvalid, 0);
        for (int a = 0; a <= 6; a++) do_read(a);

        // directed: pull-up gating, polarity, latch vs pads
        do_write(6, 8'hFF);
        do_write(0, 8'h0F);
        do_write(1, 8'hA5);
        pad_in = 8'h3C;
        do_read(9);
        do_write(9, 8'h96);
        pad_in = 8'h00;
        do_read(10);
        do_write(10, 8'h5A);
        do_read(10);

        // R6 read-only mirrors
        flg = 8'hC3; cap = 8'h7E;
        do_write(7, 8'h11);
        do_write(8, 8'h22);
        do_read(7);
        do_read(8);

        // R8 unmapped
        do_write(11, 8'hEE);
        do_write(31, 8'hEE);
        do_read(11);
        do_read(31);

        // R11 simultaneous strobes: write 0x03, read dropped
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = AW'(3); bus_wdata = 8'h6B;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        m[3] = 8'h6B;
        chk(bus_rvalid == 1'b0 && irq_clr == 1'b0, "R11 read dropped", bus_rvalid, 0);
        chk(irq_ref == 8'h6B, "R11 write done", irq_ref, 8'h6B);

        // R7 back-to-back reads 0x09 then 0x02
        pad_in = 8'hF0;
        bus_rd = 1'b1; bus_addr = AW'(9);
        @(negedge clk);
        chk(bus_rvalid && bus_rdata == (8'hF0 ^ m[1]), "R7 b2b first", bus_rdata, 8'hF0 ^ m[1]);
        chk(irq_clr == 1'b1, "R9 b2b clr", irq_clr, 1);
        bus_addr = AW'(2);
        @(negedge clk);
        bus_rd = 1'b0;
        chk(bus_rvalid && bus_rdata == m[2], "R7 b2b second", bus_rdata, m[2]);
        chk(irq_clr == 1'b0, "R9 no clr", irq_clr, 0);
        @(negedge clk);
        chk(bus_rvalid == 1'b0, "R7 b2b end", bus_rvalid, 0);

        // constrained random
        for (int k = 0; k < 400; k++) begin
            int a;
            logic [7:0] d;
            a = (($urandom % 8) == 0) ? int'($urandom % 32) : int'($urandom % 11);
            d = 8'($urandom);
            pad_in = 8'($urandom);
            flg = 8'($urandom);
            cap = 8'($urandom);
            if ($urandom % 2 == 0) do_write(a, d);
            else do_read(a);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule